// File: doc/BRIEF.md
# Floating-Point Status Flag Unit

This block holds the status word of a single-precision floating-point unit. The arithmetic datapath is not part of it. After each operation the datapath pulses a valid strobe together with its raw exception indications: invalid, overflow, divide-by-zero, underflow, inexact, and a combined input-or-output denormal indication. The unit replaces the per-operation cause bits with these indications. It accumulates sticky flags for the conditions whose trap enable is off, keeps a summary bit in step with the flags, and raises a one-cycle exception request when an enabled cause occurs.

Software may load the status word at any time. The rounding mode held in the word is driven out continuously to the datapath. A separate compare strobe carries a relation code and turns it into integer-style condition outputs.

Top module: `fpstat_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the status word, `exc_req`, `cond_z`, `cond_s` and `cond_o` all become 0.
- R2: An update has `op_valid` high and `sw_we` low. On an update, status bits 2..6 (invalid, overflow, divide-by-zero, underflow, inexact) take `op_exc[0..4]`, and all earlier cause bits are discarded.
- R3: On an update, flag bit 26+i (i = 0..4, in the order of R2) is set when `op_exc[i]` is 1 and enable bit 10+i is 0. Flag bits are never cleared by an update.
- R4: On an update, cause bit 7 (unimplemented processing) becomes `op_denorm` AND NOT bit 8 (denormal flush control).
- R5: Bit 31 of the status word always equals the OR of flag bits 26..30.
- R6: `exc_req` is high for exactly the one cycle after an update where ({CE, op_exc} AND {1, enables 14..10}) is non-zero; CE is always treated as enabled. `exc_vector` is constantly 21.
- R7: `rnd_mode` equals status bits 1..0, encoded as 0 nearest-even, 1 toward zero, 2 toward +infinity, 3 toward -infinity.
- R8: A write with `sw_we` loads bits 0,1,8,10..14,26..30 from `sw_wdata`. Cause bits 2..7 become the old value AND the written value, so a write can clear them but not set them. Written bit 31 is ignored and the summary is recomputed. Bits 9 and 15..25 always read 0.
- R9: When `sw_we` and `op_valid` are high in the same cycle, only the write takes effect, and no exception request follows.
- R10: On `cmp_valid`, one cycle later `cmp_rel` 0 (equal) gives only `cond_z`, 1 (less) only `cond_s`, 2 (greater) none, and 3 (unordered) only `cond_o`. Between compares these outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation result strobe |
| op_exc | input | 5 | Raw exception bits: invalid, overflow, div-by-zero, underflow, inexact (bit 0..4) |
| op_denorm | input | 1 | Input or output denormal seen |
| sw_we | input | 1 | Software write strobe |
| sw_wdata | input | 32 | Software write data |
| cmp_valid | input | 1 | Compare result strobe |
| cmp_rel | input | 2 | Compare relation code |
| status | output | 32 | Current status word |
| rnd_mode | output | 2 | Rounding mode to the datapath |
| exc_req | output | 1 | Exception request pulse |
| exc_vector | output | 8 | Exception vector number |
| cond_z | output | 1 | Compare equal |
| cond_s | output | 1 | Compare less-than |
| cond_o | output | 1 | Compare unordered |

## Verification
Directed updates run with all enables on and then all off. These cases separate the cause path from the sticky-flag path, and show whether an enabled cause traps without leaving a flag behind. A denormal is applied with the flush control set and then clear, which isolates the gating of the unimplemented cause and shows that this cause traps even when every enable is off. Random sparse exception patterns are mixed with random software writes, including writes that collide with updates. These show whether writes can only clear causes, whether reserved bits stay zero, and whether the write wins over the update. All four relation codes are applied to the compare outputs.

// File: rtl/fpstat_pkg.sv
// Shared layout of the floating-point status word.
// Assumes a 32-bit word with the field positions below; the datapath
// and software both decode these positions.
package fpstat_pkg;

    localparam int WORD_W    = 32;
    localparam int NUM_IEEE  = 5;   // invalid, overflow, div0, underflow, inexact
    localparam int RM_LSB    = 0;
    localparam int RM_W      = 2;
    localparam int CAUSE_LSB = 2;
    localparam int CE_BIT    = CAUSE_LSB + NUM_IEEE;
    localparam int DN_BIT    = CE_BIT + 1;
    localparam int EN_LSB    = 10;
    localparam int FLAG_LSB  = 26;
    localparam int FS_BIT    = FLAG_LSB + NUM_IEEE;
    localparam int VEC_W     = 8;

    typedef enum logic [RM_W-1:0] {
        RM_NEAREST = 2'd0,
        RM_ZERO    = 2'd1,
        RM_POS_INF = 2'd2,
        RM_NEG_INF = 2'd3
    } rnd_mode_e;

    typedef enum logic [1:0] {
        REL_EQ = 2'd0,
        REL_LT = 2'd1,
        REL_GT = 2'd2,
        REL_UN = 2'd3
    } cmp_rel_e;

    // Build a mask of w ones starting at bit lsb.
    function automatic logic [WORD_W-1:0] field_mask(input int lsb, input int w);
        logic [WORD_W-1:0] m;
        m = '0;
        for (int i = 0; i < w; i++) m[lsb+i] = 1'b1;
        return m;
    endfunction

    localparam logic [WORD_W-1:0] CAUSE_MASK = field_mask(CAUSE_LSB, NUM_IEEE + 1);
    localparam logic [WORD_W-1:0] WR_MASK    = field_mask(RM_LSB, RM_W)
                                             | field_mask(DN_BIT, 1)
                                             | field_mask(EN_LSB, NUM_IEEE)
                                             | field_mask(FLAG_LSB, NUM_IEEE);
    localparam logic [WORD_W-1:0] IMPL_MASK  = WR_MASK | CAUSE_MASK | field_mask(FS_BIT, 1);

endpackage

// File: rtl/fpstat_op_eval.sv
// Next status word after an operation result, plus the trap decision.
// Purely combinational; assumes cur is the registered status word and
// that enables and flush control are taken from it, not from the new word.
module fpstat_op_eval
    import fpstat_pkg::*;
(
    input  logic [WORD_W-1:0]   cur,
    input  logic [NUM_IEEE-1:0] exc,
    input  logic                denorm,
    output logic [WORD_W-1:0]   nxt,
    output logic                raise
);
    logic [NUM_IEEE-1:0] new_flag;
    logic                ce_cause;

    // Per-condition sticky flag: accumulates only while its trap is masked.
    for (genvar i = 0; i < NUM_IEEE; i++) begin : g_flag
        assign new_flag[i] = cur[FLAG_LSB+i] | (exc[i] & ~cur[EN_LSB+i]);
    end

    assign ce_cause = denorm & ~cur[DN_BIT];

    // Assemble the updated word: fresh causes, merged flags, summary.
    always_comb begin
        nxt                          = cur;
        nxt[CAUSE_LSB +: NUM_IEEE]   = exc;
        nxt[CE_BIT]                  = ce_cause;
        nxt[FLAG_LSB +: NUM_IEEE]    = new_flag;
        nxt[FS_BIT]                  = |new_flag;
    end

    // Trap when any cause meets its enable; the unimplemented cause cannot be masked.
    assign raise = |({ce_cause, exc} & {1'b1, cur[EN_LSB +: NUM_IEEE]});

endmodule

// File: rtl/fpstat_sw_merge.sv
// Next status word after a software write.
// Combinational; plain fields load directly, causes can only be cleared,
// the summary bit is rebuilt and reserved bits are forced to zero.
module fpstat_sw_merge
    import fpstat_pkg::*;
(
    input  logic [WORD_W-1:0] cur,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] nxt
);
    // Merge write data with the held causes and recompute the summary.
    always_comb begin
        nxt         = (wdata & WR_MASK) | (cur & wdata & CAUSE_MASK);
        nxt[FS_BIT] = |nxt[FLAG_LSB +: NUM_IEEE];
    end

endmodule

// File: rtl/fpstat_cmp_flags.sv
// Registers integer condition outputs from a compare relation code.
// Assumes one relation per cmp_valid strobe; outputs hold between strobes.
module fpstat_cmp_flags
    import fpstat_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmp_valid,
    input  logic [1:0] cmp_rel,
    output logic       cond_z,
    output logic       cond_s,
    output logic       cond_o
);
    cmp_rel_e rel;
    assign rel = cmp_rel_e'(cmp_rel);

    // Capture the condition triple on each compare strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cond_z <= 1'b0;
            cond_s <= 1'b0;
            cond_o <= 1'b0;
        end else if (cmp_valid) begin
            cond_z <= (rel == REL_EQ);
            cond_s <= (rel == REL_LT);
            cond_o <= (rel == REL_UN);
        end
    end

    // R10
    cmp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cond_z, cond_s, cond_o}));

    // R10
    cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_valid |=> $stable({cond_z, cond_s, cond_o}));

endmodule

// File: rtl/fpstat_unit.sv
// Floating-point status flag unit: holds the status word, applies
// operation results and software writes (write wins), issues the
// exception request and drives the rounding mode and compare conditions.
// Assumes at most one operation result per cycle.
module fpstat_unit
    import fpstat_pkg::*;
#(
    parameter int EXC_VECTOR = 21
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_valid,
    input  logic [4:0]          op_exc,
    input  logic                op_denorm,
    input  logic                sw_we,
    input  logic [31:0]         sw_wdata,
    input  logic                cmp_valid,
    input  logic [1:0]          cmp_rel,
    output logic [31:0]         status,
    output logic [1:0]          rnd_mode,
    output logic                exc_req,
    output logic [7:0]          exc_vector,
    output logic                cond_z,
    output logic                cond_s,
    output logic                cond_o
);
    logic [WORD_W-1:0] status_q;
    logic [WORD_W-1:0] op_next;
    logic [WORD_W-1:0] wr_next;
    logic              op_raise;
    logic              exc_req_q;
    logic              op_take;

    assign op_take = op_valid & ~sw_we;

    fpstat_op_eval u_op_eval (
        .cur    (status_q),
        .exc    (op_exc),
        .denorm (op_denorm),
        .nxt    (op_next),
        .raise  (op_raise)
    );

    fpstat_sw_merge u_sw_merge (
        .cur   (status_q),
        .wdata (sw_wdata),
        .nxt   (wr_next)
    );

    fpstat_cmp_flags u_cmp_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmp_valid (cmp_valid),
        .cmp_rel   (cmp_rel),
        .cond_z    (cond_z),
        .cond_s    (cond_s),
        .cond_o    (cond_o)
    );

    // Status register: software write has priority over an operation result.
    always_ff @(posedge clk) begin
        if (!rst_n)       status_q <= '0;
        else if (sw_we)   status_q <= wr_next;
        else if (op_valid) status_q <= op_next;
    end

    // One-cycle exception request following an accepted trapping update.
    always_ff @(posedge clk) begin
        if (!rst_n) exc_req_q <= 1'b0;
        else        exc_req_q <= op_take & op_raise;
    end

    assign status     = status_q;
    assign rnd_mode   = status_q[RM_LSB +: RM_W];
    assign exc_req    = exc_req_q;
    assign exc_vector = VEC_W'(EXC_VECTOR);

    // R8
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q & ~IMPL_MASK) == '0);

    // R5
    fs_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_q[FS_BIT] == |status_q[FLAG_LSB +: NUM_IEEE]);

    // R3
    flags_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_we |=> ((status_q[FLAG_LSB +: NUM_IEEE] & $past(status_q[FLAG_LSB +: NUM_IEEE]))
                    == $past(status_q[FLAG_LSB +: NUM_IEEE])));

    // R9
    write_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_we |=> !exc_req_q);

    // R4
    flush_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_take && status_q[DN_BIT]) |=> !status_q[CE_BIT]);

    // R6
    req_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req_q |-> (status_q[CE_BIT] ||
                       |(status_q[CAUSE_LSB +: NUM_IEEE] & status_q[EN_LSB +: NUM_IEEE])));

endmodule

// File: tb/fpstat_unit_bench.sv
module fpstat_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_valid, op_denorm, sw_we, cmp_valid;
    logic [4:0]  op_exc;
    logic [31:0] sw_wdata;
    logic [1:0]  cmp_rel;
    logic [31:0] status;
    logic [1:0]  rnd_mode;
    logic        exc_req, cond_z, cond_s, cond_o;
    logic [7:0]  exc_vector;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [31:0] m_st;
    logic        m_req, m_z, m_s, m_o;

    always #2.5 clk = ~clk;

    fpstat_unit u_fpstat_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_exc(op_exc),
        .op_denorm(op_denorm), .sw_we(sw_we), .sw_wdata(sw_wdata),
        .cmp_valid(cmp_valid), .cmp_rel(cmp_rel), .status(status),
        .rnd_mode(rnd_mode), .exc_req(exc_req), .exc_vector(exc_vector),
        .cond_z(cond_z), .cond_s(cond_s), .cond_o(cond_o)
    );

    function automatic logic [31:0] model_op(logic [31:0] s, logic [4:0] e, logic d);
        logic [31:0] n = s;
        n[6:2]   = e;
        n[7]     = d & ~s[8];
        n[30:26] = s[30:26] | (e & ~s[14:10]);
        n[31]    = |n[30:26];
        return n;
    endfunction

    function automatic logic model_raise(logic [31:0] s, logic [4:0] e, logic d);
        return (d & ~s[8]) | (|(e & s[14:10]));
    endfunction

    function automatic logic [31:0] model_wr(logic [31:0] s, logic [31:0] w);
        logic [31:0] n = (w & 32'h7C00_7D03) | (s & w & 32'h0000_00FC);
        n[31] = |n[30:26];
        return n;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all();
        chk("R2 causes",      {26'd0, status[6:2]},   {26'd0, m_st[6:2]});
        chk("R4 CE cause",    {31'd0, status[7]},     {31'd0, m_st[7]});
        chk("R3 flags",       {27'd0, status[30:26]}, {27'd0, m_st[30:26]});
        chk("R5 summary",     {31'd0, status[31]},    {31'd0, m_st[31]});
        chk("R7 rounding",    {30'd0, rnd_mode},      {30'd0, m_st[1:0]});
        chk("R8 word",        status,                 m_st);
        chk("R6 request",     {31'd0, exc_req},       {31'd0, m_req});
        chk("R6 vector",      {24'd0, exc_vector},    32'd21);
        chk("R10 conditions", {29'd0, cond_z, cond_s, cond_o}, {29'd0, m_z, m_s, m_o});
    endtask

    // Drive one cycle at the falling edge, model it at the rising edge, check at the next falling edge.
    task automatic apply(input logic sw, input logic [31:0] wd, input logic op,
                         input logic [4:0] ex, input logic dn, input logic cv,
                         input logic [1:0] rel);
        sw_we = sw; sw_wdata = wd; op_valid = op; op_exc = ex; op_denorm = dn;
        cmp_valid = cv; cmp_rel = rel;
        @(posedge clk);
        m_req = 1'b0;
        if (sw)      m_st = model_wr(m_st, wd);
        else if (op) begin
            m_req = model_raise(m_st, ex, dn);
            m_st  = model_op(m_st, ex, dn);
        end
        if (cv) begin
            m_z = (rel == 2'd0); m_s = (rel == 2'd1); m_o = (rel == 2'd3);
        end
        @(negedge clk);
        check_all();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; sw_we = 0; sw_wdata = '1; op_valid = 1; op_exc = '1;
        op_denorm = 1; cmp_valid = 1; cmp_rel = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        m_st = '0; m_req = 0; m_z = 0; m_s = 0; m_o = 0;
        check_all();                                  // R1 reset state
        rst_n = 1'b1;

        // R7 / R4: rounding toward +inf, flush on, all enables on
        apply(1, 32'hFFFF_FFFE, 0, 0, 0, 0, 0);
        apply(1, 32'h0000_7D02, 0, 0, 0, 0, 0);
        apply(0, 0, 1, 5'b00000, 1, 0, 0);            // R4: flushed denormal, no CE, no request
        apply(0, 0, 1, 5'b00001, 0, 0, 0);            // R6: enabled invalid traps, no flag (R3)
        apply(0, 0, 1, 5'b00000, 0, 0, 0);            // R2: causes cleared
        // enables off, flush off
        apply(1, 32'h0000_0001, 0, 0, 0, 0, 0);
        apply(0, 0, 1, 5'b10100, 0, 0, 0);            // R3: flags set, no request
        apply(0, 0, 1, 5'b00000, 1, 0, 0);            // R6: CE always enabled
        apply(0, 0, 1, 5'b00010, 0, 0, 0);            // R3: flags accumulate
        apply(1, 32'h8000_0000, 1, 5'b11111, 1, 0, 0); // R9/R8: write wins, bit 31 ignored
        apply(1, 32'h03FF_83FF, 0, 0, 0, 0, 0);        // R8: reserved bits stay zero
        // R10: each relation code
        for (int r = 0; r < 4; r++) apply(0, 0, 0, 0, 0, 1, 2'(r));
        apply(0, 0, 0, 0, 0, 0, 2'd1);                // R10: hold

        for (int k = 0; k < 3000; k++) begin
            logic        sw  = ($urandom % 8) == 0;
            logic [31:0] wd  = $urandom;
            logic        op  = ($urandom % 4) != 0;
            logic [4:0]  ex  = 5'($urandom & $urandom);
            logic        dn  = ($urandom % 6) == 0;
            logic        cv  = ($urandom % 3) == 0;
            logic [1:0]  rel = 2'($urandom);
            apply(sw, wd, op, ex, dn, cv, rel);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule